// File: doc/BRIEF.md
# Smart-Card T=0 Character Receiver with Error Signalling

This block receives asynchronous T=0 characters from the single shared I/O line of a smart-card interface. A falling edge on the line starts a character. The block confirms the start bit at its middle. It then samples eight data bits, least significant first, and a parity bit, each at the middle of its bit cell. A character that passes the parity check is handed out as one byte. The sampling grid comes from an external tick, `half_tick_i`, that pulses once every half bit time.

When the parity check fails, the block always raises a one-cycle error flag. If error signalling is enabled, the block also drives the shared line low for one bit time inside the two-bit guard window. The sender sees this low level as a request to send the character again. A character rejected in this way is dropped, and the receiver waits for the repeated copy. When error signalling is off, the faulty byte is still delivered, together with the error flag.

Position numbering: the line input passes through a two-stage synchroniser. The first `half_tick_i` pulse after the synchronised falling edge is half-tick 1 (position 0.5). Half-tick n corresponds to position n/2 bit times.

Top module: `t0_rx`

## Requirements
- R1: After reset is released with the line idle high, `line_oe_o`, `rx_valid_o` and `parity_err_o` are all 0.
- R2: If the synchronised line is high again at half-tick 1, the falling edge is treated as a glitch. No valid byte, no error flag and no line drive follow from it.
- R3: Data bit k (k = 0..7) is sampled at half-tick 2k+3, and bit 0 is the least significant. If the eight data bits together with the parity bit (half-tick 19) contain an even number of ones, `rx_valid_o` is high for exactly one cycle, in the cycle after the half-tick-19 edge, and `rx_data_o` holds the byte.
- R4: If the nine bits contain an odd number of ones, `parity_err_o` is high for exactly one cycle, in the cycle after the half-tick-19 edge. This happens whatever the enable setting is.
- R5: If `err_sig_en_i` is 1 at half-tick 19 and parity fails, `line_oe_o` rises after the half-tick-21 edge (position 10.5) and falls after the half-tick-23 edge (position 11.5). It is therefore high for exactly two half-tick periods.
- R6: `line_oe_o` stays 0 for characters with correct parity, and also for any character that arrives while `err_sig_en_i` is 0.
- R7: A parity-failed character is delivered with `rx_valid_o` only when error signalling is disabled. With signalling enabled it is not delivered, and the retransmitted copy is received normally.
- R8: Falling edges after half-tick 19 and before the guard ends at half-tick 24 do not start a new character. This includes edges during the block's own error pulse. The first falling edge after half-tick 24 starts reception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| half_tick_i | input | 1 | One-cycle pulse every half bit time |
| line_i | input | 1 | Level of the shared I/O line |
| err_sig_en_i | input | 1 | Enables the low pulse on parity error |
| line_oe_o | output | 1 | When high, the line is pulled low |
| rx_valid_o | output | 1 | One-cycle strobe for an accepted byte |
| rx_data_o | output | DATA_W | Last accepted byte |
| parity_err_o | output | 1 | One-cycle strobe for a parity failure |

## Verification
The half-tick counter drives every sample point, so a wrong count shows up within one character. It appears either as a shifted byte on `rx_data_o`, or as an error pulse one half-tick early or late, which the per-clock reference model reports in the cycle it differs. A stuck pending-error flag would drive the line on a good character, and a sequencer that restarts too early would take guard-window noise as a start bit. Both faults appear at the ports within the same character, as an unexpected `line_oe_o` or a spurious strobe.

// File: rtl/t0_rx_pkg.sv
package t0_rx_pkg;

  typedef enum logic {
    SEQ_IDLE,
    SEQ_BUSY
  } seq_state_e;

  // half-tick numbers counted from the confirmed start edge
  function automatic int unsigned parity_pos(int unsigned w);
    return 2 * w + 3;
  endfunction

  function automatic int unsigned pulse_on_pos(int unsigned w);
    return 2 * w + 5;
  endfunction

  function automatic int unsigned pulse_off_pos(int unsigned w);
    return 2 * w + 7;
  endfunction

  function automatic int unsigned guard_end_pos(int unsigned w);
    return 2 * w + 8;
  endfunction

endpackage

// File: rtl/t0_line_sync.sv
module t0_line_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic line_s_o,
  output logic fall_o
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   line_d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q[0] <= 1'b1;
    else         sync_q[0] <= line_i;
  end

  for (genvar g = 1; g < SYNC_STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sync_q[g] <= 1'b1;
      else         sync_q[g] <= sync_q[g-1];
    end
  end

  assign line_s_o = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) line_d_q <= 1'b1;
    else         line_d_q <= line_s_o;
  end

  assign fall_o = line_d_q & ~line_s_o;

endmodule

// File: rtl/t0_rx_seq.sv
module t0_rx_seq
  import t0_rx_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic fall_i,
  input  logic line_s_i,
  output logic busy_o,
  output logic bit_smp_o,
  output logic par_smp_o,
  output logic pulse_on_o,
  output logic pulse_off_o,
  output logic done_o
);

  localparam int unsigned DONE_N = guard_end_pos(DATA_W);
  localparam int unsigned CNT_W  = $clog2(DONE_N + 1);
  localparam logic [CNT_W-1:0] START_C = CNT_W'(1);
  localparam logic [CNT_W-1:0] FIRST_C = CNT_W'(3);
  localparam logic [CNT_W-1:0] LAST_C  = CNT_W'(parity_pos(DATA_W) - 2);
  localparam logic [CNT_W-1:0] PAR_C   = CNT_W'(parity_pos(DATA_W));
  localparam logic [CNT_W-1:0] ON_C    = CNT_W'(pulse_on_pos(DATA_W));
  localparam logic [CNT_W-1:0] OFF_C   = CNT_W'(pulse_off_pos(DATA_W));
  localparam logic [CNT_W-1:0] DONE_C  = CNT_W'(DONE_N);

  seq_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;
  logic             step;
  logic             false_start;

  assign cnt_nxt     = cnt_q + 1'b1;
  assign step        = (state_q == SEQ_BUSY) && tick_i;
  assign false_start = step && (cnt_nxt == START_C) && line_s_i;

  assign busy_o      = (state_q == SEQ_BUSY);
  assign bit_smp_o   = step && cnt_nxt[0] && (cnt_nxt >= FIRST_C) && (cnt_nxt <= LAST_C);
  assign par_smp_o   = step && (cnt_nxt == PAR_C);
  assign pulse_on_o  = step && (cnt_nxt == ON_C);
  assign pulse_off_o = step && (cnt_nxt == OFF_C);
  assign done_o      = step && (cnt_nxt == DONE_C);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        SEQ_IDLE: begin
          if (fall_i) begin
            state_q <= SEQ_BUSY;
            cnt_q   <= '0;
          end
        end
        SEQ_BUSY: begin
          if (step) cnt_q <= cnt_nxt;
          if (false_start || done_o) state_q <= SEQ_IDLE;
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  // R8: counter never passes the guard end
  a_r8_cnt_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= DONE_C);

endmodule

// File: rtl/t0_rx_data.sv
module t0_rx_data #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_smp_i,
  input  logic              par_smp_i,
  input  logic              done_i,
  input  logic              line_s_i,
  input  logic              sig_en_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o,
  output logic              perr_o,
  output logic              nack_pend_o
);

  logic [DATA_W-1:0] shift_q;
  logic              bad;

  assign bad = (^shift_q) ^ line_s_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) shift_q <= '0;
    else if (bit_smp_i) shift_q <= {line_s_i, shift_q[DATA_W-1:1]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o      <= '0;
      valid_o     <= 1'b0;
      perr_o      <= 1'b0;
      nack_pend_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      perr_o  <= 1'b0;
      if (par_smp_i) begin
        perr_o      <= bad;
        nack_pend_o <= bad & sig_en_i;
        if (!bad || !sig_en_i) begin
          valid_o <= 1'b1;
          data_o  <= shift_q;
        end
      end else if (done_i) begin
        nack_pend_o <= 1'b0;
      end
    end
  end

  a_r3_valid_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  a_r4_perr_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    perr_o |=> !perr_o);

endmodule

// File: rtl/t0_err_drive.sv
module t0_err_drive (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pulse_on_i,
  input  logic pulse_off_i,
  input  logic pend_i,
  output logic oe_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  oe_o <= 1'b0;
    else if (pulse_on_i && pend_i) oe_o <= 1'b1;
    else if (pulse_off_i)          oe_o <= 1'b0;
  end

  // R5: pulse spans two half-ticks, so never a single cycle
  a_r5_oe_not_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oe_o) |=> oe_o);

endmodule

// File: rtl/t0_rx.sv
module t0_rx #(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              half_tick_i,
  input  logic              line_i,
  input  logic              err_sig_en_i,
  output logic              line_oe_o,
  output logic              rx_valid_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              parity_err_o
);

  logic line_s, fall;
  logic busy, bit_smp, par_smp, pulse_on, pulse_off, done;
  logic nack_pend;

  t0_line_sync #(.SYNC_STAGES(SYNC_STAGES)) i_sync (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .line_i   (line_i),
    .line_s_o (line_s),
    .fall_o   (fall)
  );

  t0_rx_seq #(.DATA_W(DATA_W)) i_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (half_tick_i),
    .fall_i      (fall),
    .line_s_i    (line_s),
    .busy_o      (busy),
    .bit_smp_o   (bit_smp),
    .par_smp_o   (par_smp),
    .pulse_on_o  (pulse_on),
    .pulse_off_o (pulse_off),
    .done_o      (done)
  );

  t0_rx_data #(.DATA_W(DATA_W)) i_data (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bit_smp_i   (bit_smp),
    .par_smp_i   (par_smp),
    .done_i      (done),
    .line_s_i    (line_s),
    .sig_en_i    (err_sig_en_i),
    .data_o      (rx_data_o),
    .valid_o     (rx_valid_o),
    .perr_o      (parity_err_o),
    .nack_pend_o (nack_pend)
  );

  t0_err_drive i_drv (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pulse_on_i  (pulse_on),
    .pulse_off_i (pulse_off),
    .pend_i      (nack_pend),
    .oe_o        (line_oe_o)
  );

  a_r5_oe_inside_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_oe_o |-> busy);

  a_r6_oe_needs_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(line_oe_o) |-> nack_pend);

  a_r7_oe_excludes_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_oe_o |-> !rx_valid_o);

endmodule

// File: tb/test_t0_rx.sv
module test_t0_rx;

  localparam time CLK_PERIOD = 10ns;
  localparam int  TICK_DIV   = 8;
  localparam int  SYNC       = 2;
  localparam int  WDOG       = 100000;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       half_tick = 1'b0;
  logic       snd = 1'b1;
  logic       err_en = 1'b0;
  logic       line_oe, rx_valid, parity_err;
  logic [7:0] rx_data;
  wire        line = snd & ~line_oe;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  t0_rx i_t0_rx (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .half_tick_i  (half_tick),
    .line_i       (line),
    .err_sig_en_i (err_en),
    .line_oe_o    (line_oe),
    .rx_valid_o   (rx_valid),
    .rx_data_o    (rx_data),
    .parity_err_o (parity_err)
  );

  int div = 0;
  always @(negedge clk) begin
    div = (div + 1) % TICK_DIV;
    half_tick = (div == 0);
  end

  task automatic chk(string tag, bit ok, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // behavioural reference model, evaluated per clock
  bit   m_hist[$];
  bit   m_prev, m_busy, m_oe, m_valid, m_perr, m_pend;
  int   m_n;
  bit   m_byte[8];
  logic [7:0] m_data;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_hist = {};
      for (int i = 0; i < SYNC; i++) m_hist.push_back(1'b1);
      m_prev = 1; m_busy = 0; m_oe = 0; m_valid = 0; m_perr = 0; m_pend = 0;
      m_n = 0; m_data = '0;
      for (int i = 0; i < 8; i++) m_byte[i] = 0;
    end else begin
      bit ls, fall, bad;
      ls = m_hist.pop_front();
      m_hist.push_back(line);
      fall = m_prev && !ls;
      m_prev = ls;
      m_valid = 0;
      m_perr = 0;
      if (!m_busy) begin
        if (fall) begin m_busy = 1; m_n = 0; end
      end else if (half_tick) begin
        m_n++;
        if (m_n == 1) begin
          if (ls) m_busy = 0;
        end else if (m_n % 2 == 1 && m_n >= 3 && m_n <= 17) begin
          m_byte[(m_n - 3) / 2] = ls;
        end else if (m_n == 19) begin
          bad = ls;
          for (int i = 0; i < 8; i++) bad ^= m_byte[i];
          m_perr = bad;
          m_pend = bad && err_en;
          if (!bad || !err_en) begin
            m_valid = 1;
            for (int i = 0; i < 8; i++) m_data[i] = m_byte[i];
          end
        end else if (m_n == 21) begin
          if (m_pend) m_oe = 1;
        end else if (m_n == 23) begin
          m_oe = 0;
        end else if (m_n == 24) begin
          m_busy = 0;
          m_pend = 0;
        end
      end
    end
  end

  // event monitor and per-clock comparison
  int   n_valid, n_perr, n_oe;
  logic [7:0] last_data;

  always @(negedge clk) begin
    cycles++;
    if (cycles > WDOG) begin
      chk("watchdog", 1'b0, cycles, WDOG);
      finish_run();
    end
    if (rst_ni) begin
      chk("R3 valid", rx_valid === m_valid, rx_valid, m_valid);
      if (m_valid) chk("R3 data", rx_data === m_data, rx_data, m_data);
      chk("R4 perr", parity_err === m_perr, parity_err, m_perr);
      chk("R5 oe", line_oe === m_oe, line_oe, m_oe);
      if (rx_valid) begin n_valid++; last_data = rx_data; end
      if (parity_err) n_perr++;
      if (line_oe) n_oe++;
    end
  end

  task automatic clr();
    n_valid = 0; n_perr = 0; n_oe = 0;
  endtask

  task automatic wait_tick();
    @(posedge clk);
    while (!half_tick) @(posedge clk);
  endtask

  task automatic send_char(logic [7:0] d, bit bad, bit noise);
    logic par;
    par = (^d) ^ bad;
    wait_tick();
    @(negedge clk) snd = 1'b0;
    for (int b = 0; b < 10; b++) begin
      wait_tick();
      wait_tick();
      @(negedge clk);
      snd = (b < 8) ? d[b] : (b == 8) ? par : 1'b1;
    end
    if (noise) begin
      wait_tick();
      @(negedge clk) snd = 1'b0;
      wait_tick();
      wait_tick();
      @(negedge clk) snd = 1'b1;
      repeat (3) wait_tick();
    end else begin
      repeat (6) wait_tick();
    end
  endtask

  task automatic good_char(logic [7:0] d);
    clr();
    send_char(d, 1'b0, 1'b0);
    chk("R3 count", n_valid == 1, n_valid, 1);
    chk("R3 byte", last_data == d, last_data, d);
    chk("R6 no drive", n_oe == 0, n_oe, 0);
  endtask

  initial begin
    clr();
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 oe", line_oe === 1'b0, line_oe, 0);
    chk("R1 valid", rx_valid === 1'b0, rx_valid, 0);
    chk("R1 perr", parity_err === 1'b0, parity_err, 0);

    good_char(8'hA5);
    good_char(8'h00);
    good_char(8'hFF);
    good_char(8'h01);
    good_char(8'h80);

    // R2: short glitch
    clr();
    wait_tick();
    @(negedge clk) snd = 1'b0;
    repeat (2) @(negedge clk);
    snd = 1'b1;
    repeat (6) wait_tick();
    chk("R2 no byte", n_valid == 0, n_valid, 0);
    chk("R2 no perr", n_perr == 0, n_perr, 0);
    chk("R2 no drive", n_oe == 0, n_oe, 0);
    good_char(8'h3C);

    // R5/R7: signalled error, then retransmission
    err_en = 1'b1;
    clr();
    send_char(8'h5A, 1'b1, 1'b0);
    chk("R4 flag", n_perr == 1, n_perr, 1);
    chk("R7 dropped", n_valid == 0, n_valid, 0);
    chk("R5 width", n_oe == 2 * TICK_DIV, n_oe, 2 * TICK_DIV);
    clr();
    send_char(8'h5A, 1'b0, 1'b0);
    chk("R7 resent", n_valid == 1 && last_data == 8'h5A, last_data, 8'h5A);
    chk("R6 good no drive", n_oe == 0, n_oe, 0);

    // R8: noise in guard with own pulse, then a new character
    clr();
    send_char(8'hC3, 1'b1, 1'b1);
    chk("R8 no restart", n_valid == 0 && n_perr == 1, n_valid, 0);
    good_char(8'h96);

    // R6/R7: signalling disabled
    err_en = 1'b0;
    clr();
    send_char(8'h7E, 1'b1, 1'b0);
    chk("R6 disabled no drive", n_oe == 0, n_oe, 0);
    chk("R7 delivered", n_valid == 1 && last_data == 8'h7E, last_data, 8'h7E);
    chk("R4 flag disabled", n_perr == 1, n_perr, 1);

    // R8: guard noise without a pulse
    clr();
    send_char(8'h11, 1'b0, 1'b1);
    chk("R8 single byte", n_valid == 1, n_valid, 1);

    repeat (10) @(negedge clk);
    finish_run();
  end

endmodule